// File: doc/BRIEF.md
# Branch Trace Output Latch

This block belongs to the memory-bus side of a cache controller. It reports taken branches to the memory bus controller while execution tracing is switched on. Each time the processor flags a taken branch and the trace-enable bit of the control word is set, the block stores two things: the three lowest bits of the branch target linear address and the default operand size. It then raises a request for a branch-trace special cycle.

The stored values appear on a 4-bit trace output starting in the clock where that cycle's address strobe is sampled low. They stay on the output until the cycle finishes. The cycle finishes when bus-hold asserts, or one clock after the first of next-address or ready. At every other time the output is driven low, so snoop-type cycles never see leftover trace data.

A taken branch that arrives while a trace cycle is pending or running goes into a one-entry buffer. If that buffer is already full, the new branch is dropped and a sticky overflow flag is raised.

Top module: `branch_trace_latch`

## Requirements
- R1: A synchronous reset (`rst_i` high) clears the trace output, the request, the buffered entry and the overflow flag. After reset all three outputs read 0.
- R2: In a valid window, `trace_o[2:0]` equals target address bits 0, 1 and 2 in that order, and `trace_o[3]` is 1 for a 32-bit default operand size and 0 for a 16-bit one.
- R3: A taken-branch strobe is accepted only when bit 1 of `trace_ctl_i` is 1. Otherwise it is ignored: `req_o`, `trace_o` and `ovf_o` are unaffected.
- R4: `req_o` rises in the clock after a branch is accepted and stays high until a clock edge where `ads_n_i` is sampled low.
- R5: In the clock where `req_o` is high and `ads_n_i` is low, `trace_o` already shows the stored values.
- R6: After the strobe, `trace_o` holds the same value through the clock where `na_n_i` or `rdy_n_i` is first seen low, and through one further clock. After that it reads 0.
- R7: While `hold_i` is high, `trace_o` reads 0. A window that sees `hold_i` high ends at that edge.
- R8: Outside a valid window, `trace_o` is 0, including while `req_o` is waiting for the strobe.
- R9: Address and size are stored at the edge where the taken strobe is accepted. Later changes on `tgt_addr_i` or `opsize32_i` do not change the reported values.
- R10: A branch accepted while a cycle is pending or active is buffered. When the current window ends, `req_o` is high in the next clock and the buffered values are reported in the following window.
- R11: A branch accepted while the buffer is full, and while no slot frees at that edge, is dropped. `ovf_o` then goes high and stays high until reset.
- R12: `na_n_i` and `rdy_n_i` low in the same clock end the window exactly as either one alone does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trace_ctl_i | input | CTL_W | Test/trace control word; bit EN_BIT enables tracing |
| br_taken_i | input | 1 | Taken-branch strobe, active high |
| tgt_addr_i | input | ADDR_W | Low bits of branch target linear address |
| opsize32_i | input | 1 | Default operand size is 32 bits |
| ads_n_i | input | 1 | Address strobe of the memory bus, active low |
| hold_i | input | 1 | Bus-hold, active high |
| na_n_i | input | 1 | Next-address, active low |
| rdy_n_i | input | 1 | Ready, active low |
| req_o | output | 1 | Branch-trace special cycle requested |
| trace_o | output | ADDR_W+1 | Trace output: address bits and operand size |
| ovf_o | output | 1 | Sticky buffer overflow |

## Verification
The assertions check on every clock that the output stays low while a request waits and while bus-hold is asserted. They also check that a request never drops without a strobe, that the reported value does not change mid-window, that the one-clock tail always ends, and that the overflow flag is sticky. Only the bench scenarios can show what must hold across a sequence of events: the exact bit mapping of stored values, the point where capture happens against later input changes, the queuing order of back-to-back branches, and the dropping of a third branch. The bench compares every clock against a reference model kept as a small list of outstanding entries.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2,
    ST_TAIL = 2'd3
  } btm_state_e;

  // A bus cycle terminates on the first of next-address or ready (both active low).
  function automatic logic end_seen(input logic na_n, input logic rdy_n);
    return !na_n || !rdy_n;
  endfunction

endpackage

// File: rtl/btm_capture.sv
module btm_capture #(
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 1,
  parameter int ADDR_W = 3,
  localparam int PAY_W = ADDR_W + 1
) (
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              opsize32_i,
  output logic              fire_o,
  output logic [PAY_W-1:0]  data_o
);

  logic trace_on;

  generate
    if (EN_BIT < CTL_W) begin : g_en_ok
      assign trace_on = ctl_i[EN_BIT];
    end else begin : g_en_none
      assign trace_on = 1'b0;
    end
  endgenerate

  assign fire_o = taken_i && trace_on;

  // Address bits land on the low positions one for one; size flag on top.
  for (genvar g = 0; g < ADDR_W; g++) begin : g_abit
    assign data_o[g] = addr_i[g];
  end
  assign data_o[PAY_W-1] = opsize32_i;

endmodule

// File: rtl/btm_queue.sv
module btm_queue #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic [W-1:0] dout_o,
  output logic         ovf_o
);

  logic         full_q;
  logic [W-1:0] data_q;
  logic         ovf_q;
  logic         room;

  assign room = !full_q || pop_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      full_q <= 1'b0;
      data_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push_i && room) begin
        data_q <= din_i;
        full_q <= 1'b1;
      end else if (pop_i) begin
        full_q <= 1'b0;
      end
      if (push_i && !room) ovf_q <= 1'b1;
    end
  end

  assign full_o = full_q;
  assign dout_o = data_q;
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/btm_window.sv
module btm_window
  import btm_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         cap_fire_i,
  input  logic [W-1:0] cap_data_i,
  input  logic         q_full_i,
  input  logic [W-1:0] q_data_i,
  input  logic         ads_n_i,
  input  logic         hold_i,
  input  logic         na_n_i,
  input  logic         rdy_n_i,
  output logic         q_push_o,
  output logic         q_pop_o,
  output logic         req_o,
  output logic         win_o,
  output logic         tail_o,
  output logic         busy_o,
  output logic [W-1:0] cur_o
);

  btm_state_e   st_q, st_d;
  logic [W-1:0] cur_q, cur_d;
  logic         busy, fin, strobe, load_new, load_q, ends;

  assign busy   = (st_q != ST_IDLE);
  assign strobe = (st_q == ST_PEND) && !ads_n_i;
  assign ends   = end_seen(na_n_i, rdy_n_i);

  // Window finishes: hold during strobe or active phase, or tail clock done.
  assign fin = ((strobe || st_q == ST_ACT) && hold_i) || (st_q == ST_TAIL);

  assign load_q   = fin && q_full_i;
  assign load_new = cap_fire_i && (!busy || (fin && !q_full_i));
  assign q_pop_o  = load_q;
  assign q_push_o = cap_fire_i && busy && !(fin && !q_full_i);

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    if (load_q)        cur_d = q_data_i;
    else if (load_new) cur_d = cap_data_i;

    if (!busy || fin) begin
      st_d = (load_q || load_new) ? ST_PEND : ST_IDLE;
    end else begin
      unique case (st_q)
        ST_PEND: if (strobe) st_d = ends ? ST_TAIL : ST_ACT;
        ST_ACT:  if (ends)   st_d = ST_TAIL;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
    end
  end

  assign req_o  = (st_q == ST_PEND);
  assign win_o  = (strobe || st_q == ST_ACT || st_q == ST_TAIL) && !hold_i;
  assign tail_o = (st_q == ST_TAIL);
  assign busy_o = busy;
  assign cur_o  = cur_q;

endmodule

// File: rtl/branch_trace_latch.sv
module branch_trace_latch #(
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 1,
  parameter int ADDR_W = 3,
  localparam int OUT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CTL_W-1:0]  trace_ctl_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic              opsize32_i,
  input  logic              ads_n_i,
  input  logic              hold_i,
  input  logic              na_n_i,
  input  logic              rdy_n_i,
  output logic              req_o,
  output logic [OUT_W-1:0]  trace_o,
  output logic              ovf_o
);

  logic             cap_fire;
  logic [OUT_W-1:0] cap_data;
  logic             q_push, q_pop, q_full;
  logic [OUT_W-1:0] q_data;
  logic             win_open;
  logic             win_tail;
  logic             fsm_busy;
  logic [OUT_W-1:0] cur_data;

  btm_capture #(.CTL_W(CTL_W), .EN_BIT(EN_BIT), .ADDR_W(ADDR_W)) u_cap (
    .ctl_i      (trace_ctl_i),
    .taken_i    (br_taken_i),
    .addr_i     (tgt_addr_i),
    .opsize32_i (opsize32_i),
    .fire_o     (cap_fire),
    .data_o     (cap_data)
  );

  btm_queue #(.W(OUT_W)) u_q (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .push_i (q_push),
    .pop_i  (q_pop),
    .din_i  (cap_data),
    .full_o (q_full),
    .dout_o (q_data),
    .ovf_o  (ovf_o)
  );

  btm_window #(.W(OUT_W)) u_win (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cap_fire_i (cap_fire),
    .cap_data_i (cap_data),
    .q_full_i   (q_full),
    .q_data_i   (q_data),
    .ads_n_i    (ads_n_i),
    .hold_i     (hold_i),
    .na_n_i     (na_n_i),
    .rdy_n_i    (rdy_n_i),
    .q_push_o   (q_push),
    .q_pop_o    (q_pop),
    .req_o      (req_o),
    .win_o      (win_open),
    .tail_o     (win_tail),
    .busy_o     (fsm_busy),
    .cur_o      (cur_data)
  );

  assign trace_o = win_open ? cur_data : '0;

endmodule

// File: rtl/branch_trace_latch_chk.sv
module branch_trace_latch_chk #(
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 1,
  parameter int OUT_W  = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [CTL_W-1:0] trace_ctl_i,
  input logic             br_taken_i,
  input logic             ads_n_i,
  input logic             hold_i,
  input logic             na_n_i,
  input logic             rdy_n_i,
  input logic             req_o,
  input logic [OUT_W-1:0] trace_o,
  input logic             ovf_o,
  input logic             win_tail,
  input logic             fsm_busy
);

  p_wait_blank_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    req_o && ads_n_i |-> trace_o == '0);

  p_hold_blank_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_i |-> trace_o == '0);

  p_req_waits_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    req_o && ads_n_i |=> req_o);

  p_no_spurious_req_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !fsm_busy && !(br_taken_i && trace_ctl_i[EN_BIT]) |=> !req_o);

  p_value_steady_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (trace_o != '0) && !win_tail && na_n_i && rdy_n_i |=> hold_i || $stable(trace_o));

  p_tail_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    win_tail |=> !win_tail);

  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_o |=> ovf_o);

endmodule

bind branch_trace_latch branch_trace_latch_chk #(
  .CTL_W(CTL_W), .EN_BIT(EN_BIT), .OUT_W(OUT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .trace_ctl_i (trace_ctl_i),
  .br_taken_i  (br_taken_i),
  .ads_n_i     (ads_n_i),
  .hold_i      (hold_i),
  .na_n_i      (na_n_i),
  .rdy_n_i     (rdy_n_i),
  .req_o       (req_o),
  .trace_o     (trace_o),
  .ovf_o       (ovf_o),
  .win_tail    (win_tail),
  .fsm_busy    (fsm_busy)
);

// File: tb/branch_trace_latch_tb.sv
module branch_trace_latch_tb;

  localparam int CTL_W  = 8;
  localparam int EN_BIT = 1;
  localparam int ADDR_W = 3;
  localparam int OUT_W  = ADDR_W + 1;
  localparam int LIMIT  = 20000;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic [CTL_W-1:0] trace_ctl_i = '0;
  logic br_taken_i = 1'b0;
  logic [ADDR_W-1:0] tgt_addr_i = '0;
  logic opsize32_i = 1'b0;
  logic ads_n_i = 1'b1, hold_i = 1'b0, na_n_i = 1'b1, rdy_n_i = 1'b1;
  logic req_o, ovf_o;
  logic [OUT_W-1:0] trace_o;

  always #5 clk = ~clk;

  branch_trace_latch #(.CTL_W(CTL_W), .EN_BIT(EN_BIT), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_i(rst_i), .trace_ctl_i(trace_ctl_i), .br_taken_i(br_taken_i),
    .tgt_addr_i(tgt_addr_i), .opsize32_i(opsize32_i), .ads_n_i(ads_n_i),
    .hold_i(hold_i), .na_n_i(na_n_i), .rdy_n_i(rdy_n_i),
    .req_o(req_o), .trace_o(trace_o), .ovf_o(ovf_o)
  );

  // Reference model: list of outstanding entries, head has a phase.
  int               n_vec = 0, n_bad = 0;
  logic [OUT_W-1:0] ent [2];
  int               cnt = 0;
  int               ph  = 0;   // 0 waiting for strobe, 1 active, 2 last clock
  logic             m_ovf = 1'b0;
  bit               done = 1'b0;

  function automatic logic [OUT_W-1:0] expect_pack(input logic [ADDR_W-1:0] a, input logic s32);
    return {s32, a};
  endfunction

  function automatic logic model_open();
    return !hold_i && cnt > 0 && ((ph == 0 && !ads_n_i) || ph != 0);
  endfunction

  task automatic compare(input string tag);
    logic [OUT_W-1:0] e_tr;
    logic e_req;
    e_tr  = model_open() ? ent[0] : '0;
    e_req = (cnt > 0) && (ph == 0);
    n_vec++;
    if (trace_o !== e_tr || req_o !== e_req || ovf_o !== m_ovf) begin
      n_bad++;
      $display("FAIL %s: trace=%h req=%b ovf=%b expected trace=%h req=%b ovf=%b",
               tag, trace_o, req_o, ovf_o, e_tr, e_req, m_ovf);
    end
  endtask

  task automatic model_edge();
    logic fin, acc;
    if (rst_i) begin
      cnt = 0; ph = 0; m_ovf = 1'b0;
      return;
    end
    acc = br_taken_i && trace_ctl_i[EN_BIT];
    fin = 1'b0;
    if (cnt > 0) begin
      if (ph == 2) fin = 1'b1;
      else if (hold_i && (ph == 1 || !ads_n_i)) fin = 1'b1;
      else if (ph == 1 && (!na_n_i || !rdy_n_i)) ph = 2;
      else if (ph == 0 && !ads_n_i) ph = (!na_n_i || !rdy_n_i) ? 2 : 1;
    end
    if (fin) begin
      ent[0] = ent[1]; cnt--; ph = 0;
    end
    if (acc) begin
      if (cnt < 2) begin ent[cnt] = expect_pack(tgt_addr_i, opsize32_i); cnt++; end
      else m_ovf = 1'b1;
    end
  endtask

  // Inputs are set at the falling edge; cyc checks then passes the rising edge.
  task automatic cyc(input string tag);
    #1;
    compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_in();
    br_taken_i = 1'b0; ads_n_i = 1'b1; hold_i = 1'b0; na_n_i = 1'b1; rdy_n_i = 1'b1;
  endtask

  task automatic branch(input logic [ADDR_W-1:0] a, input logic s, input string tag);
    br_taken_i = 1'b1; tgt_addr_i = a; opsize32_i = s;
    cyc(tag);
    br_taken_i = 1'b0;
  endtask

  initial begin
    #(LIMIT * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    @(posedge clk); model_edge(); @(negedge clk);
    @(posedge clk); model_edge(); @(negedge clk);
    cyc("R1 reset");
    rst_i = 1'b0;
    cyc("R1 after reset");

    // R3: enable bit clear, strobe ignored
    trace_ctl_i = 8'hFD;
    branch(3'd7, 1'b1, "R3 disabled strobe");
    cyc("R3 no request");
    cyc("R3 no request");
    trace_ctl_i = 8'h02;

    // R2/R4/R5/R6/R9 main sequence
    branch(3'd5, 1'b1, "R2 capture");
    tgt_addr_i = 3'd2; opsize32_i = 1'b0;          // R9: later change ignored
    cyc("R4 request waits");
    cyc("R8 blank while waiting");
    ads_n_i = 1'b0;
    cyc("R5 valid at strobe");
    ads_n_i = 1'b1;
    cyc("R9 held value");
    cyc("R6 active");
    na_n_i = 1'b0;
    cyc("R6 next-address clock");
    na_n_i = 1'b1;
    cyc("R6 tail clock");
    cyc("R6 closed");

    // R7: hold cuts the window
    branch(3'd1, 1'b0, "R2 16-bit size");
    ads_n_i = 1'b0; cyc("R5 strobe");
    ads_n_i = 1'b1; cyc("R7 active");
    hold_i = 1'b1;  cyc("R7 hold blanks");
    hold_i = 1'b0;  cyc("R7 window over");

    // R12: both terminators together
    branch(3'd6, 1'b1, "R12 capture");
    ads_n_i = 1'b0; cyc("R12 strobe");
    ads_n_i = 1'b1; na_n_i = 1'b0; rdy_n_i = 1'b0;
    cyc("R12 both low");
    idle_in(); cyc("R12 tail");
    cyc("R12 closed");

    // R10: second branch queued
    branch(3'd3, 1'b0, "R10 first");
    branch(3'd4, 1'b1, "R10 second queued");
    ads_n_i = 1'b0; cyc("R10 first strobe");
    ads_n_i = 1'b1; rdy_n_i = 1'b0; cyc("R10 ready");
    rdy_n_i = 1'b1; cyc("R10 tail");
    cyc("R10 second request");
    ads_n_i = 1'b0; cyc("R10 second strobe");
    ads_n_i = 1'b1; na_n_i = 1'b0; cyc("R10 end");
    na_n_i = 1'b1; cyc("R10 tail");
    cyc("R10 closed");

    // R11: third branch overflows
    branch(3'd1, 1'b1, "R11 first");
    branch(3'd2, 1'b1, "R11 second");
    branch(3'd7, 1'b0, "R11 third dropped");
    cyc("R11 flag set");
    ads_n_i = 1'b0; cyc("R11 first strobe");
    ads_n_i = 1'b1; hold_i = 1'b1; cyc("R11 hold");
    hold_i = 1'b0; cyc("R11 second pending");
    ads_n_i = 1'b0; cyc("R11 second strobe");
    ads_n_i = 1'b1; rdy_n_i = 1'b0; cyc("R11 end");
    rdy_n_i = 1'b1; cyc("R11 tail");
    cyc("R11 nothing left");

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i == 2000) begin
        rst_i = 1'b1; cyc("R1 mid reset"); rst_i = 1'b0;
      end
      trace_ctl_i = 8'($urandom);
      if ($urandom % 8 != 0) trace_ctl_i[EN_BIT] = 1'b1;
      br_taken_i = ($urandom % 5) == 0;
      tgt_addr_i = ADDR_W'($urandom);
      opsize32_i = 1'($urandom);
      ads_n_i    = ($urandom % 3) != 0;
      hold_i     = ($urandom % 16) == 0;
      na_n_i     = ($urandom % 5) != 0;
      rdy_n_i    = ($urandom % 5) != 0;
      cyc("R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule